// File: doc/BRIEF.md
# Register-Indirect Move Engine

This block is a small sequencer that copies values of 1, 2 or 4 bytes from one place to another inside a byte-addressed register file. The register file itself lives outside the block. The engine reaches it through one 4-byte read port and one write port of variable length. Each operand is either direct or indirect. A direct operand is a field at a fixed byte address, and its own field width sets how many bytes are accessed. An indirect operand names a one-byte pointer register, and the value held there is the byte address used for the access. An indirect access always moves the command's transfer size.

A command arrives as a one-cycle pulse while the engine is idle. It carries:
- the transfer size;
- per side: the direct or indirect choice, the pointer update flags and the register address;
- an optional count register.

The engine then runs these steps in order:
1. It reads the source pointer, the destination pointer and the count.
2. It moves one element per cycle. Before an access, a pointer with the decrement flag drops by the size. After an access, a pointer with the increment flag rises by the size.
3. It writes the updated pointers back to their registers.
4. It pulses `done` for one cycle.

Top module: `regind_mover`

## Requirements
- R1: Size code 0, 1 and 2 selects a transfer of 1, 2 and 4 bytes; code 3 also means 4 bytes. An indirect operand accesses exactly that many bytes, starting at the address held in its pointer register. Every write carries a length of 1, 2 or 4.
- R2: A direct operand is accessed at its own address with its own field width (same encoding as R1). The value read is zero-extended, or truncated to its low bytes, to the width written at the destination.
- R3: With the decrement flag, a pointer is reduced by the transfer size before it is used for the access.
- R4: With the increment flag, a pointer is raised by the transfer size after it has been used for the access.
- R5: With the count enabled, the whole element transfer is repeated as many times as the count byte holds, including the pointer updates. Without the count, the transfer happens exactly once.
- R6: A count byte of zero makes the command a no-operation. No byte of the register file changes, and `done` still pulses.
- R7: The count register keeps its value after the command, unless a data write of the command itself targets it.
- R8: Updated pointers are written back as one byte each when the loop ends, the source pointer first and then the destination pointer. When both flags are set on one side, that pointer ends unchanged. A pointer with neither flag set is not written.
- R9: `done` is high for exactly one cycle per command. `busy` is high from the cycle after acceptance until `done`. No write happens while idle.
- R10: Pointer arithmetic wraps modulo 256. Register-file byte addresses, including the bytes inside a multi-byte access, wrap modulo 128.
- R11: A direct destination stays at its fixed address on every iteration, so after a looped command it holds the last element moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_size | input | 2 | Transfer size code |
| src_ind | input | 1 | Source is addressed through a pointer |
| src_inc | input | 1 | Post-increment the source pointer |
| src_dec | input | 1 | Pre-decrement the source pointer |
| src_reg | input | 7 | Source field or source pointer address |
| src_fw | input | 2 | Field width code of a direct source |
| dst_ind | input | 1 | Destination is addressed through a pointer |
| dst_inc | input | 1 | Post-increment the destination pointer |
| dst_dec | input | 1 | Pre-decrement the destination pointer |
| dst_reg | input | 7 | Destination field or destination pointer address |
| dst_fw | input | 2 | Field width code of a direct destination |
| cnt_en | input | 1 | Use a loop count |
| cnt_reg | input | 7 | Address of the count byte |
| rd_addr | output | 7 | Read port byte address |
| rd_data | input | 32 | Four bytes starting at rd_addr, low byte first |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 7 | Write byte address |
| wr_len | output | 3 | Number of bytes written |
| wr_data | output | 32 | Write data, low byte at wr_addr |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach involve overlap. One case is a source pointer that walks across the very bytes the same loop has just written, or across its own pointer or count register. Another is a pointer that crosses the top of the register file. Random commands are drawn with full 8-bit pointers and short loop counts over a small shared address range, so that such overlaps and wraps occur often. Directed cases pin down pre-decrement, post-increment, both flags together, a zero count and the 127-to-0 wrap. A bench function reproduces each command byte by byte and compares the whole register file after every `done`.

// File: rtl/regind_mover.sv
module regind_mover #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_size,
  input  logic              src_ind,
  input  logic              src_inc,
  input  logic              src_dec,
  input  logic [ADDR_W-1:0] src_reg,
  input  logic [1:0]        src_fw,
  input  logic              dst_ind,
  input  logic              dst_inc,
  input  logic              dst_dec,
  input  logic [ADDR_W-1:0] dst_reg,
  input  logic [1:0]        dst_fw,
  input  logic              cnt_en,
  input  logic [ADDR_W-1:0] cnt_reg,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [2:0]        wr_len,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done
);
  typedef enum logic [2:0] {IDLE, PSRC, PDST, CNT, RUN, WBS, WBD, FIN} st_t;
  st_t st;

  logic [1:0]        c_size, c_sfw, c_dfw;
  logic              c_sind, c_sinc, c_sdec, c_dind, c_dinc, c_ddec, c_cen;
  logic [ADDR_W-1:0] c_sreg, c_dreg, c_creg;
  logic [7:0]        ps, pd, cnt;

  function automatic logic [2:0] nbytes(input logic [1:0] code);
    return (code == 2'd0) ? 3'd1 : (code == 2'd1) ? 3'd2 : 3'd4;
  endfunction

  function automatic logic [31:0] bmask(input logic [2:0] n);
    return (n == 3'd1) ? 32'h0000_00ff : (n == 3'd2) ? 32'h0000_ffff : 32'hffff_ffff;
  endfunction

  logic [2:0] sz, srcw, dstw;
  logic [7:0] sz8, s_use, d_use;

  assign sz    = nbytes(c_size);
  assign sz8   = {5'd0, sz};
  assign srcw  = c_sind ? sz : nbytes(c_sfw);
  assign dstw  = c_dind ? sz : nbytes(c_dfw);
  assign s_use = c_sdec ? ps - sz8 : ps;
  assign d_use = c_ddec ? pd - sz8 : pd;
  assign busy  = (st != IDLE);
  assign done  = (st == FIN);

  always_comb begin
    case (st)
      PSRC:    rd_addr = c_sreg;
      PDST:    rd_addr = c_dreg;
      CNT:     rd_addr = c_creg;
      RUN:     rd_addr = c_sind ? s_use[ADDR_W-1:0] : c_sreg;
      default: rd_addr = '0;
    endcase
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_len  = 3'd1;
    wr_data = '0;
    case (st)
      RUN: begin
        wr_en   = 1'b1;
        wr_addr = c_dind ? d_use[ADDR_W-1:0] : c_dreg;
        wr_len  = dstw;
        wr_data = rd_data & bmask(srcw);
      end
      WBS: begin
        wr_en   = c_sind & (c_sinc | c_sdec);
        wr_addr = c_sreg;
        wr_data = {24'd0, ps};
      end
      WBD: begin
        wr_en   = c_dind & (c_dinc | c_ddec);
        wr_addr = c_dreg;
        wr_data = {24'd0, pd};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      {c_size, c_sfw, c_dfw} <= '0;
      {c_sind, c_sinc, c_sdec, c_dind, c_dinc, c_ddec, c_cen} <= '0;
      {c_sreg, c_dreg, c_creg} <= '0;
      ps <= '0; pd <= '0; cnt <= '0;
    end else begin
      case (st)
        IDLE: if (cmd_valid) begin
          c_size <= cmd_size; c_sfw <= src_fw; c_dfw <= dst_fw;
          c_sind <= src_ind;  c_sinc <= src_inc; c_sdec <= src_dec;
          c_dind <= dst_ind;  c_dinc <= dst_inc; c_ddec <= dst_dec;
          c_cen  <= cnt_en;   c_sreg <= src_reg; c_dreg <= dst_reg; c_creg <= cnt_reg;
          st <= PSRC;
        end
        PSRC: begin ps <= rd_data[7:0]; st <= PDST; end
        PDST: begin pd <= rd_data[7:0]; st <= CNT; end
        CNT: begin
          cnt <= c_cen ? rd_data[7:0] : 8'd1;
          st  <= (c_cen && rd_data[7:0] == 8'd0) ? FIN : RUN;
        end
        RUN: begin
          if (c_sind) ps <= s_use + (c_sinc ? sz8 : 8'd0);
          if (c_dind) pd <= d_use + (c_dinc ? sz8 : 8'd0);
          cnt <= cnt - 8'd1;
          if (cnt == 8'd1) st <= WBS;
        end
        WBS: st <= WBD;
        WBD: st <= FIN;
        default: st <= IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !wr_en); // R9
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_len == 3'd1 || wr_len == 3'd2 || wr_len == 3'd4)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN && cnt > 8'd1) |=> (st == RUN && cnt == $past(cnt) - 8'd1)); // R5
  AST_ZERO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CNT && c_cen && rd_data[7:0] == 8'd0) |=> (done && !wr_en)); // R6
  AST_WB_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == WBS || st == WBD) && wr_en) |-> wr_len == 3'd1); // R8
endmodule

// File: tb/test_regind_mover.sv
module test_regind_mover;
  localparam int AW = 7;
  localparam int NB = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_size = '0, src_fw = '0, dst_fw = '0;
  logic          src_ind = 0, src_inc = 0, src_dec = 0, dst_ind = 0, dst_inc = 0, dst_dec = 0, cnt_en = 0;
  logic [AW-1:0] src_reg = '0, dst_reg = '0, cnt_reg = '0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0]   rd_data, wr_data;
  logic          wr_en, busy, done;
  logic [2:0]    wr_len;

  logic [7:0] rf [NB];
  logic [7:0] mdl[NB];
  int total = 0, bad = 0;

  regind_mover #(.ADDR_W(AW)) i_regind_mover (
    .clk, .rst_n, .cmd_valid, .cmd_size, .src_ind, .src_inc, .src_dec, .src_reg, .src_fw,
    .dst_ind, .dst_inc, .dst_dec, .dst_reg, .dst_fw, .cnt_en, .cnt_reg,
    .rd_addr, .rd_data, .wr_en, .wr_addr, .wr_len, .wr_data, .busy, .done);

  always_comb rd_data = {rf[AW'(rd_addr + 3)], rf[AW'(rd_addr + 2)], rf[AW'(rd_addr + 1)], rf[rd_addr]};

  always @(posedge clk)
    if (wr_en)
      for (int i = 0; i < 4; i++)
        if (i < int'(wr_len)) rf[AW'(wr_addr + i)] <= wr_data[8*i +: 8];

  function automatic int nb(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 4;
  endfunction

  task automatic model_run();
    int sz = nb(cmd_size);
    int sw = src_ind ? sz : nb(src_fw);
    int dw = dst_ind ? sz : nb(dst_fw);
    logic [7:0] ps = mdl[src_reg], pd = mdl[dst_reg];
    int n = cnt_en ? int'(mdl[cnt_reg]) : 1;
    for (int k = 0; k < n; k++) begin
      logic [7:0] sa, da;
      logic [7:0] v[4];
      sa = src_dec ? ps - 8'(sz) : ps;
      da = dst_dec ? pd - 8'(sz) : pd;
      for (int i = 0; i < 4; i++)
        v[i] = (i < sw) ? mdl[AW'((src_ind ? sa[AW-1:0] : src_reg) + i)] : 8'd0;
      for (int i = 0; i < dw; i++) mdl[AW'((dst_ind ? da[AW-1:0] : dst_reg) + i)] = v[i];
      if (src_ind) ps = sa + (src_inc ? 8'(sz) : 8'd0);
      if (dst_ind) pd = da + (dst_inc ? 8'(sz) : 8'd0);
    end
    if (n > 0) begin
      if (src_ind && (src_inc || src_dec)) mdl[src_reg] = ps;
      if (dst_ind && (dst_inc || dst_dec)) mdl[dst_reg] = pd;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cmd(input logic [1:0] sz, input logic si, input logic sinc, input logic sdec,
                         input logic [AW-1:0] sr, input logic [1:0] sfw,
                         input logic di, input logic dinc, input logic ddec,
                         input logic [AW-1:0] dr, input logic [1:0] dfw,
                         input logic ce, input logic [AW-1:0] cr);
    cmd_size = sz; src_ind = si; src_inc = sinc; src_dec = sdec; src_reg = sr; src_fw = sfw;
    dst_ind = di; dst_inc = dinc; dst_dec = ddec; dst_reg = dr; dst_fw = dfw;
    cnt_en = ce; cnt_reg = cr;
  endtask

  task automatic exec(input string req);
    int cyc = 0;
    int mism = -1;
    for (int i = 0; i < NB; i++) mdl[i] = rf[i];
    model_run();
    @(negedge clk); cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    check({req, " done seen"}, {31'd0, done}, 32'd1);
    @(negedge clk);
    check("R9 done one cycle", {30'd0, done, busy}, 32'd0);
    for (int i = 0; i < NB; i++) if (rf[i] !== mdl[i] && mism < 0) mism = i;
    if (mism < 0) check(req, 32'd0, 32'd0);
    else check({req, " regfile byte"}, {16'(mism), 8'd0, rf[mism]}, {16'(mism), 8'd0, mdl[mism]});
  endtask

  task automatic fill_rf();
    for (int i = 0; i < NB; i++) rf[i] = 8'($urandom);
  endtask

  initial begin
    process::self().srandom(32'h5eed_1234);
    fill_rf();
    repeat (3) @(negedge clk);
    check("R9 reset state", {29'd0, busy, done, wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    rf[1] = 8'h20; rf[2] = 8'h40;
    set_cmd(2'd1, 1, 0, 0, 7'd1, 2'd0, 1, 0, 0, 7'd2, 2'd0, 0, 7'd0);
    exec("R1 ind-ind half");
    check("R1 moved half", {rf[8'h41], rf[8'h40]}, {rf[8'h21], rf[8'h20]});
    check("R8 no writeback", {24'd0, rf[1]}, 32'h20);

    rf[8'h30] = 8'hA5;
    set_cmd(2'd2, 0, 0, 0, 7'h30, 2'd0, 0, 0, 0, 7'h50, 2'd2, 0, 7'd0);
    exec("R2 zero extend");
    check("R2 zero extend value", {rf[8'h53], rf[8'h52], rf[8'h51], rf[8'h50]}, 32'h0000_00A5);
    set_cmd(2'd0, 0, 0, 0, 7'h50, 2'd2, 0, 0, 0, 7'h60, 2'd0, 0, 7'd0);
    exec("R2 truncate");

    rf[3] = 8'h38;
    set_cmd(2'd2, 1, 0, 1, 7'd3, 2'd0, 0, 0, 0, 7'h10, 2'd2, 0, 7'd0);
    exec("R3 predecrement");
    check("R3 pointer written back", {24'd0, rf[3]}, 32'h34);

    rf[4] = 8'h44; rf[0] = 8'd3; rf[5] = 8'h20;
    set_cmd(2'd1, 1, 1, 0, 7'd5, 2'd0, 1, 1, 0, 7'd4, 2'd0, 1, 7'd0);
    exec("R4 R5 postincrement loop");
    check("R4 dst pointer +6", {24'd0, rf[4]}, 32'h4A);
    check("R7 count kept", {24'd0, rf[0]}, 32'd3);

    rf[0] = 8'd0;
    set_cmd(2'd2, 1, 1, 0, 7'd5, 2'd0, 1, 1, 0, 7'd4, 2'd0, 1, 7'd0);
    exec("R6 zero count nop");
    check("R6 pointer untouched", {24'd0, rf[4]}, 32'h4A);

    rf[6] = 8'h22; rf[0] = 8'd2;
    set_cmd(2'd2, 1, 1, 1, 7'd6, 2'd0, 0, 0, 0, 7'h70, 2'd2, 1, 7'd0);
    exec("R8 R11 inc+dec, direct dest loop");
    check("R8 pointer net unchanged", {24'd0, rf[6]}, 32'h22);

    rf[7] = 8'h7E;
    set_cmd(2'd2, 1, 1, 0, 7'd7, 2'd0, 0, 0, 0, 7'h18, 2'd2, 0, 7'd0);
    exec("R10 wrap");
    check("R10 wrapped bytes", {rf[8'h1B], rf[8'h1A], rf[8'h19], rf[8'h18]},
          {rf[1], rf[0], rf[127], rf[126]});
    check("R10 pointer 8-bit", {24'd0, rf[7]}, 32'h82);

    for (int t = 0; t < 300; t++) begin
      logic [AW-1:0] cr;
      if (t % 50 == 0) fill_rf();
      cr = AW'($urandom_range(0, 15));
      rf[cr] = 8'($urandom_range(0, 5));
      set_cmd(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), AW'($urandom_range(0, 40)), 2'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), AW'($urandom_range(0, 40)), 2'($urandom),
              1'($urandom), cr);
      exec("R1 R2 R3 R4 R5 R7 R8 R10 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule